// File: doc/BRIEF.md
# Hybrid Static-Dynamic Branch Predictor

This front-end unit guesses the direction and destination of branches for the fetch stage. It keeps one direct-mapped table. Each slot holds a valid flag, an address tag, a 2-bit saturating confidence counter and a remembered destination, so direction history and target share one structure. A lookup presents the branch address and the sign of its displacement. When the tag matches, the counter decides the direction. When it does not, a fixed rule applies: a backward branch is guessed taken and a forward branch is guessed not taken.

Fetch is steered away from the sequential path only when the guess is taken and the table supplies a destination. A taken guess from the fixed rule has no stored destination, so fetch carries on sequentially. When execution resolves a branch, the resolution port trains the slot, or claims a slot if the branch was taken and had none. It also compares the outcome with what fetch actually did. On a disagreement it raises a flush request one cycle later, together with the address fetch should resume from.

Top module: `brpred_top`

## Requirements
- R1: On a lookup whose address has no valid slot with a matching tag, `pred_hit` is 0 and `pred_taken` equals `lk_back` (1 = negative displacement).
- R2: On a lookup that hits, `pred_taken` equals bit 1 of the slot's counter (counter 2 or 3 means taken), whatever the value of `lk_back`.
- R3: A resolution that hits moves the counter up by one if taken and down by one if not taken, holding at 0 and at 3.
- R4: A taken resolution that misses claims the slot with counter 2, the resolved target and the new tag, replacing any earlier branch at that slot.
- R5: A not-taken resolution that misses leaves the table unchanged.
- R6: A lookup that hits with a taken guess sets `pred_redirect` and drives the stored target on `pred_next`. A taken resolution that hits replaces the stored target with the resolved one.
- R7: Whenever `pred_redirect` is 0 (including a taken guess from the static rule), `pred_next` is `lk_pc + 4`.
- R8: `flush` rises in the cycle after a resolution in which `rs_taken` differs from `rs_pred_redirect`, or in which both are 1 and `rs_target` differs from `rs_pred_target`. `flush_addr` is then `rs_target` for a taken branch and `rs_pc + 4` otherwise. With no resolution, there is no flush in the next cycle.
- R9: When a lookup and a resolution fall in the same cycle, the lookup sees the table as it was before that cycle's update. The update is visible from the next cycle on.
- R10: The slot index is address bits [9:2] (256 slots) and the tag is bits [31:10]. Two addresses with the same index and different tags do not hit each other's slot.
- R11: Synchronous reset invalidates every slot and clears `flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_back | input | 1 | Displacement is negative (backward branch) |
| pred_hit | output | 1 | Lookup found a matching slot |
| pred_taken | output | 1 | Guessed direction |
| pred_redirect | output | 1 | Fetch should jump to `pred_next` |
| pred_next | output | 32 | Next fetch address |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | 32 | Address of the resolving branch |
| rs_taken | input | 1 | Actual direction |
| rs_target | input | 32 | Actual destination when taken |
| rs_pred_redirect | input | 1 | Fetch was redirected for this branch |
| rs_pred_target | input | 32 | Address fetch was redirected to |
| flush | output | 1 | Misprediction: flush and restart fetch |
| flush_addr | output | 32 | Correct restart address |

## Verification
Lookups are sent to an empty slot with both displacement signs, which shows the static rule apart from the counter path. The same branch is then trained through long runs of taken and not-taken outcomes. The lookup after each run tells correct saturation apart from counter wrap-around at both ends. One resolution changes only the destination and another changes only the direction. These show target mismatch and direction mismatch as separate flush causes. An address that aliases at the same index checks tag replacement. A lookup and a resolution issued together on one branch show that the lookup reads the table contents from before the update.

// File: rtl/brpred_pkg.sv
package brpred_pkg;
    localparam int ADDR_W     = 32;
    localparam int IDX_W      = 8;
    localparam int IDX_LSB    = 2;
    localparam int INSN_BYTES = 4;
    localparam int TAG_W      = ADDR_W - IDX_W - IDX_LSB;
    localparam int DEPTH      = 1 << IDX_W;

    typedef logic [1:0]        ctr_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;

    localparam ctr_t CTR_MIN    = 2'b00;
    localparam ctr_t CTR_MAX    = 2'b11;
    localparam ctr_t CTR_WEAK_T = 2'b10;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        ctr_t  ctr;
        addr_t tgt;
    } slot_t;

    typedef struct packed {
        logic  hit;
        logic  taken;
        logic  redir;
        addr_t next;
    } guess_t;

    function automatic idx_t idx_of(addr_t a);
        return a[IDX_LSB +: IDX_W];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic addr_t seq_next(addr_t a);
        return a + addr_t'(INSN_BYTES);
    endfunction

    function automatic ctr_t ctr_step(ctr_t c, logic tk);
        if (tk) return (c == CTR_MAX) ? c : c + 2'd1;
        return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/brpred_store.sv
module brpred_store
    import brpred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  idx_t  rd_a_idx,
    output slot_t rd_a_slot,
    input  idx_t  rd_b_idx,
    output slot_t rd_b_slot,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  slot_t wr_slot
);
    slot_t tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        slot_t slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= '0;
            else if (wr_en && wr_idx == idx_t'(i))
                slot_q <= wr_slot;
        end
        assign tbl[i] = slot_q;
    end

    assign rd_a_slot = tbl[rd_a_idx];
    assign rd_b_slot = tbl[rd_b_idx];

    // R11: a reset cycle leaves the read slot invalid
    assert_clear_R11: assert property (@(posedge clk)
        $past(rst) |-> !rd_a_slot.vld);

    // R9: a write shows up on the read port from the following cycle
    assert_wr_visible_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(wr_en) && rd_a_idx == $past(wr_idx)
        |-> rd_a_slot == $past(wr_slot));
endmodule

// File: rtl/brpred_lookup.sv
module brpred_lookup
    import brpred_pkg::*;
(
    input  logic   lk_valid,
    input  addr_t  lk_pc,
    input  logic   lk_back,
    input  slot_t  slot,
    output guess_t guess
);
    logic match;

    always_comb begin
        match       = slot.vld && (slot.tag == tag_of(lk_pc));
        guess.hit   = lk_valid && match;
        guess.taken = lk_valid && (match ? slot.ctr[1] : lk_back);
        guess.redir = guess.hit && slot.ctr[1];
        guess.next  = guess.redir ? slot.tgt : seq_next(lk_pc);
    end
endmodule

// File: rtl/brpred_resolve.sv
module brpred_resolve
    import brpred_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rs_valid,
    input  addr_t rs_pc,
    input  logic  rs_taken,
    input  addr_t rs_target,
    input  logic  rs_pred_redirect,
    input  addr_t rs_pred_target,
    input  slot_t cur,
    output logic  wr_en,
    output idx_t  wr_idx,
    output slot_t wr_slot,
    output logic  flush,
    output addr_t flush_addr
);
    logic  match, wrong;
    addr_t fix;

    always_comb begin
        match       = cur.vld && (cur.tag == tag_of(rs_pc));
        wr_idx      = idx_of(rs_pc);
        wr_slot.vld = 1'b1;
        wr_slot.tag = tag_of(rs_pc);
        if (match) begin
            wr_en       = rs_valid;
            wr_slot.ctr = ctr_step(cur.ctr, rs_taken);
            wr_slot.tgt = rs_taken ? rs_target : cur.tgt;
        end else begin
            wr_en       = rs_valid && rs_taken;
            wr_slot.ctr = CTR_WEAK_T;
            wr_slot.tgt = rs_target;
        end
        wrong = (rs_taken != rs_pred_redirect) ||
                (rs_taken && (rs_target != rs_pred_target));
        fix   = rs_taken ? rs_target : seq_next(rs_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush      <= 1'b0;
            flush_addr <= '0;
        end else begin
            flush      <= rs_valid && wrong;
            flush_addr <= fix;
        end
    end

    // R8: direction disagreement always flushes next cycle
    assert_dir_flush_R8: assert property (@(posedge clk) disable iff (rst)
        rs_valid && (rs_taken != rs_pred_redirect) |=> flush);

    // R8: no resolution, no flush
    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |=> !flush);

    // R8: not-taken restart address is the fall-through
    assert_fix_seq_R8: assert property (@(posedge clk) disable iff (rst)
        rs_valid && !rs_taken |=> flush_addr == $past(rs_pc) + addr_t'(INSN_BYTES));

    // R5: a not-taken miss never writes
    assert_no_alloc_R5: assert property (@(posedge clk) disable iff (rst)
        rs_valid && !rs_taken && !(cur.vld && cur.tag == tag_of(rs_pc)) |-> !wr_en);
endmodule

// File: rtl/brpred_top.sv
module brpred_top
    import brpred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic              lk_back,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic              pred_redirect,
    output logic [ADDR_W-1:0] pred_next,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    input  logic [ADDR_W-1:0] rs_target,
    input  logic              rs_pred_redirect,
    input  logic [ADDR_W-1:0] rs_pred_target,
    output logic              flush,
    output logic [ADDR_W-1:0] flush_addr
);
    slot_t  lk_slot, rs_slot, wr_slot;
    idx_t   wr_idx;
    logic   wr_en;
    guess_t guess;

    brpred_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_a_idx  (idx_of(lk_pc)),
        .rd_a_slot (lk_slot),
        .rd_b_idx  (idx_of(rs_pc)),
        .rd_b_slot (rs_slot),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_slot   (wr_slot)
    );

    brpred_lookup u_lookup (
        .lk_valid (lk_valid),
        .lk_pc    (lk_pc),
        .lk_back  (lk_back),
        .slot     (lk_slot),
        .guess    (guess)
    );

    brpred_resolve u_resolve (
        .clk              (clk),
        .rst              (rst),
        .rs_valid         (rs_valid),
        .rs_pc            (rs_pc),
        .rs_taken         (rs_taken),
        .rs_target        (rs_target),
        .rs_pred_redirect (rs_pred_redirect),
        .rs_pred_target   (rs_pred_target),
        .cur              (rs_slot),
        .wr_en            (wr_en),
        .wr_idx           (wr_idx),
        .wr_slot          (wr_slot),
        .flush            (flush),
        .flush_addr       (flush_addr)
    );

    assign pred_hit      = guess.hit;
    assign pred_taken    = guess.taken;
    assign pred_redirect = guess.redir;
    assign pred_next     = guess.next;

    // R1: a miss follows the displacement sign
    assert_static_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !pred_hit |-> pred_taken == lk_back);

    // R6: redirect only on a taken hit
    assert_redirect_R6: assert property (@(posedge clk) disable iff (rst)
        pred_redirect |-> pred_hit && pred_taken);

    // R7: without redirect, fetch goes sequential
    assert_seq_R7: assert property (@(posedge clk) disable iff (rst)
        lk_valid && !pred_redirect |-> pred_next == lk_pc + addr_t'(INSN_BYTES));

    // R4: a taken resolution is found by a lookup on the next cycle
    assert_alloc_hit_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(rs_valid && rs_taken) && lk_valid && lk_pc == $past(rs_pc)
        |-> pred_hit);
endmodule

// File: tb/brpred_top_tb_top.sv
module brpred_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0, lk_back = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pred_hit, pred_taken, pred_redirect;
    logic [31:0] pred_next;
    logic        rs_valid = 1'b0, rs_taken = 1'b0, rs_pred_redirect = 1'b0;
    logic [31:0] rs_pc = '0, rs_target = '0, rs_pred_target = '0;
    logic        flush;
    logic [31:0] flush_addr;

    always #10 clk = ~clk;   // 50 MHz

    brpred_top dut_i (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_back(lk_back),
        .pred_hit(pred_hit), .pred_taken(pred_taken),
        .pred_redirect(pred_redirect), .pred_next(pred_next),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_target(rs_target), .rs_pred_redirect(rs_pred_redirect),
        .rs_pred_target(rs_pred_target),
        .flush(flush), .flush_addr(flush_addr)
    );

    typedef struct {
        logic        chk_lk;
        logic        hit, tk, redir;
        logic [31:0] next;
        logic        fl;
        logic [31:0] fl_addr;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0, n_err = 0;
    logic        pend_fl = 1'b0;
    logic [31:0] pend_addr = '0;
    bit          done = 1'b0;

    localparam logic [31:0] A  = 32'h0000_1040;  // index 0x10
    localparam logic [31:0] B  = 32'h0000_1440;  // index 0x10, other tag
    localparam logic [31:0] C  = 32'h0000_2080;  // index 0x20
    localparam logic [31:0] D  = 32'h0000_1044;  // index 0x11
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_3000;
    localparam logic [31:0] T3 = 32'h0000_4000;
    localparam logic [31:0] T4 = 32'h0000_5000;

    // Driver: one cycle of stimulus plus the expected outputs for it
    task automatic step(input logic lv, input logic [31:0] lpc, input logic lb,
                        input logic rv, input logic [31:0] rpc, input logic rtk,
                        input logic [31:0] rtgt, input logic rred, input logic [31:0] rptgt,
                        input logic e_hit, input logic e_tk, input logic e_red,
                        input logic [31:0] e_next, input string req);
        exp_t e;
        @(posedge clk);
        #2;
        lk_valid = lv; lk_pc = lpc; lk_back = lb;
        rs_valid = rv; rs_pc = rpc; rs_taken = rtk; rs_target = rtgt;
        rs_pred_redirect = rred; rs_pred_target = rptgt;
        e.chk_lk = lv; e.hit = e_hit; e.tk = e_tk; e.redir = e_red; e.next = e_next;
        e.fl = pend_fl; e.fl_addr = pend_addr; e.req = req;
        sb_q.push_back(e);
        pend_fl   = rv && ((rtk != rred) || (rtk && rtgt != rptgt));
        pend_addr = rtk ? rtgt : rpc + 32'd4;
    endtask

    task automatic look(input logic [31:0] pc, input logic back, input logic e_hit,
                        input logic e_tk, input logic e_red, input logic [31:0] e_next,
                        input string req);
        step(1'b1, pc, back, 1'b0, '0, 1'b0, '0, 1'b0, '0, e_hit, e_tk, e_red, e_next, req);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                           input logic pred_red, input logic [31:0] pred_tgt, input string req);
        step(1'b0, '0, 1'b0, 1'b1, pc, tk, tgt, pred_red, pred_tgt,
             1'b0, 1'b0, 1'b0, '0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, req);
    endtask

    // Monitor: pops one expectation per cycle, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.chk_lk) begin
                n_chk++;
                if (pred_hit !== e.hit || pred_taken !== e.tk ||
                    pred_redirect !== e.redir || pred_next !== e.next) begin
                    n_err++;
                    $display("FAIL %s lookup: hit/tk/redir/next got %b%b%b %h expected %b%b%b %h",
                             e.req, pred_hit, pred_taken, pred_redirect, pred_next,
                             e.hit, e.tk, e.redir, e.next);
                end
            end
            n_chk++;
            if (flush !== e.fl || (e.fl && flush_addr !== e.fl_addr)) begin
                n_err++;
                $display("FAIL %s/R8 flush: got %b %h expected %b %h",
                         e.req, flush, flush_addr, e.fl, e.fl_addr);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        lk_valid = 1'b1; lk_pc = A;
        @(negedge clk);
        n_chk++;   // R11: reset state
        if (flush !== 1'b0 || pred_hit !== 1'b0) begin
            n_err++;
            $display("FAIL R11 reset: flush=%b hit=%b expected 0 0", flush, pred_hit);
        end
        @(posedge clk); #2; rst = 1'b0; lk_valid = 1'b0;

        look(A, 1'b1, 0, 1, 0, A + 4, "R11_R1_R7");     // empty table, backward
        look(A, 1'b0, 0, 0, 0, A + 4, "R1");            // forward
        resolve(A, 1'b0, T1, 1'b0, '0, "R5");
        look(A, 1'b1, 0, 1, 0, A + 4, "R5");            // still empty
        resolve(A, 1'b1, T1, 1'b0, '0, "R4");           // claim, ctr=2, flush to T1
        look(A, 1'b0, 1, 1, 1, T1, "R4_R2_R6");         // forward but counter says taken
        resolve(A, 1'b0, T1, 1'b1, T1, "R3");           // ctr=1, flush to A+4
        look(A, 1'b1, 1, 0, 0, A + 4, "R2");            // backward but counter says not
        resolve(A, 1'b0, T1, 1'b0, '0, "R3");           // ctr=0
        resolve(A, 1'b0, T1, 1'b0, '0, "R3");           // ctr holds 0
        resolve(A, 1'b1, T1, 1'b0, '0, "R3");           // ctr=1
        look(A, 1'b1, 1, 0, 0, A + 4, "R3_low_sat");
        resolve(A, 1'b1, T1, 1'b0, '0, "R3");           // ctr=2
        resolve(A, 1'b1, T1, 1'b1, T1, "R3");           // ctr=3
        resolve(A, 1'b1, T1, 1'b1, T1, "R3");           // ctr holds 3
        resolve(A, 1'b0, T1, 1'b1, T1, "R3");           // ctr=2
        resolve(A, 1'b0, T1, 1'b0, '0, "R3");           // ctr=1
        look(A, 1'b0, 1, 0, 0, A + 4, "R3_high_sat");
        resolve(A, 1'b1, T2, 1'b0, '0, "R6");           // ctr=2, target T2
        look(A, 1'b0, 1, 1, 1, T2, "R6");
        resolve(A, 1'b1, T2, 1'b1, T1, "R8_target");    // wrong target only
        look(B, 1'b0, 0, 0, 0, B + 4, "R10");           // same index, other tag
        resolve(B, 1'b1, T3, 1'b0, '0, "R4");           // replaces A
        look(A, 1'b0, 0, 0, 0, A + 4, "R4_R10");
        look(B, 1'b1, 1, 1, 1, T3, "R4");
        look(D, 1'b0, 0, 0, 0, D + 4, "R10");           // neighbouring index empty
        step(1'b1, C, 1'b0, 1'b1, C, 1'b1, T4, 1'b0, '0,
             0, 0, 0, C + 4, "R9");                     // old contents seen
        look(C, 1'b0, 1, 1, 1, T4, "R9");
        idle("R8");

        @(posedge clk); #2; rst = 1'b1;
        @(posedge clk); #2; rst = 1'b0;
        pend_fl = 1'b0;
        look(B, 1'b0, 0, 0, 0, B + 4, "R11");
        look(C, 1'b1, 0, 1, 0, C + 4, "R11");
        idle("R11");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule